// File: doc/BRIEF.md
# Virtual Circuit Label-Swap Forwarder

This block forwards packet headers along pre-established virtual circuits inside a small packet switch. Each header that arrives names the interface it came in on and a circuit identifier that is only meaningful on that link. The block searches a small fully associative connection table for the pair (arrival interface, identifier). If it finds a usable entry, it emits the header one cycle later with the identifier swapped for the value that the next hop expects and with the departure interface attached. Headers that find no usable entry are dropped and counted.

A management port builds and removes connections. A fixed circuit is installed in one operation with all four fields filled in. A signalled circuit is opened first with its departure identifier still unknown. This half-built entry forwards nothing until a later completion supplies the departure identifier, for instance when the acknowledgement comes back. Removing a connection frees its slot for reuse. Management operations that cannot be carried out raise a one-cycle error flag and leave the table unchanged.

Top module: `vc_swap_fwd`

## Requirements
- R1: The lookup key is the full pair (arrival interface, arrival identifier). A header whose identifier matches an entry but whose interface differs is not forwarded by that entry.
- R2: A header presented with `pkt_valid_i` that matches an active entry produces `out_valid_o` exactly one cycle later. `out_if_o` then carries the stored departure interface and `out_vci_o` the stored departure identifier. With no header presented, `out_valid_o` stays low in the next cycle.
- R3: Operation code 0 (install) creates an entry that is active at once, with departure interface `mgmt_out_if_i` and departure identifier `mgmt_out_vci_i`. A header in any later cycle uses it.
- R4: Operation code 1 (open) creates a pending entry that records only the departure interface, and matching headers are dropped. Operation code 2 (complete) on a pending entry stores `mgmt_out_vci_i` and makes the entry active.
- R5: A header that matches no entry, or matches only a pending one, raises `drop_o` for one cycle, one cycle after it arrives. In that same cycle `miss_count_o` goes up by one. In every other cycle the counter holds its value. `out_valid_o` and `drop_o` are never high together.
- R6: Operation code 3 (remove) deletes the entry with the given key. Headers with that key are dropped afterwards, and the freed slot can take a new entry even after the table was full.
- R7: An install or open for a new key while all 16 slots hold entries raises `mgmt_err_o` one cycle later and changes nothing. An install or open whose key already exists overwrites that entry without error.
- R8: When a management operation and a header lookup touch the same entry in the same cycle, the lookup uses the table contents from before the operation.
- R9: A complete whose key has no pending entry, or a remove whose key has no entry, raises `mgmt_err_o` one cycle later and leaves the table unchanged. `mgmt_err_o` is never high unless a management operation was presented in the previous cycle.
- R10: While the synchronous reset is high, and in the first cycle after it, `out_valid_o`, `drop_o` and `mgmt_err_o` are low and `miss_count_o` is zero. After reset the table is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid_i | input | 1 | A header is presented this cycle |
| pkt_if_i | input | IF_W | Arrival interface of the header |
| pkt_vci_i | input | VCI_W | Arrival circuit identifier of the header |
| out_valid_o | output | 1 | Rewritten header is valid |
| out_if_o | output | IF_W | Departure interface |
| out_vci_o | output | VCI_W | Departure circuit identifier |
| drop_o | output | 1 | The header of the previous cycle was dropped |
| miss_count_o | output | CNT_W | Running count of dropped headers |
| mgmt_valid_i | input | 1 | Management operation presented |
| mgmt_op_i | input | 2 | 0 install, 1 open, 2 complete, 3 remove |
| mgmt_in_if_i | input | IF_W | Key: arrival interface |
| mgmt_in_vci_i | input | VCI_W | Key: arrival identifier |
| mgmt_out_if_i | input | IF_W | Departure interface (install, open) |
| mgmt_out_vci_i | input | VCI_W | Departure identifier (install, complete) |
| mgmt_err_o | output | 1 | The previous management operation was refused |

## Verification
The assertions check on every cycle the properties that hold for any table contents. Each header produces exactly one outcome (forward or drop) one cycle later, and idle cycles produce neither. The drop counter moves by exactly one on a drop and otherwise holds still. An error appears only after a management operation. Which outcome a given header should get depends on the history of installs, opens, completes and removes, so that can only be shown by the bench's scenarios against its reference model. Those scenarios cover key pairing across interfaces, pending entries, a full table, slot reuse, overwrite of an existing key, and a lookup that coincides with a change to the same entry.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
  typedef enum logic [1:0] {
    OP_INSTALL  = 2'd0,
    OP_OPEN     = 2'd1,
    OP_COMPLETE = 2'd2,
    OP_REMOVE   = 2'd3
  } vcf_op_e;
endpackage

// File: rtl/vcf_match.sv
// Fully associative key compare; reports all hits and the lowest hit index.
module vcf_match #(
  parameter int N     = 16,
  parameter int IF_W  = 2,
  parameter int VCI_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][IF_W-1:0]  ent_if,
  input  logic [N-1:0][VCI_W-1:0] ent_vci,
  input  logic [IF_W-1:0]         key_if,
  input  logic [VCI_W-1:0]        key_vci,
  output logic [N-1:0]            hit_vec,
  output logic                    hit,
  output logic [IDX_W-1:0]        hit_idx
);
  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign hit_vec[gi] = ent_valid[gi] && (ent_if[gi] == key_if) && (ent_vci[gi] == key_vci);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vcf_table.sv
// Connection storage and management operations.
module vcf_table
  import vcf_pkg::*;
#(
  parameter int N     = 16,
  parameter int IF_W  = 2,
  parameter int VCI_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mgmt_valid,
  input  vcf_op_e                 mgmt_op,
  input  logic [IF_W-1:0]         mgmt_in_if,
  input  logic [VCI_W-1:0]        mgmt_in_vci,
  input  logic [IF_W-1:0]         mgmt_out_if,
  input  logic [VCI_W-1:0]        mgmt_out_vci,
  input  logic                    key_hit,
  input  logic [IDX_W-1:0]        key_idx,
  output logic [N-1:0]            ent_valid,
  output logic [N-1:0]            ent_pend,
  output logic [N-1:0][IF_W-1:0]  ent_in_if,
  output logic [N-1:0][VCI_W-1:0] ent_in_vci,
  output logic [N-1:0][IF_W-1:0]  ent_out_if,
  output logic [N-1:0][VCI_W-1:0] ent_out_vci,
  output logic                    mgmt_err
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic             wr_full, wr_done, wr_clr, err_next;
  logic [IDX_W-1:0] wr_idx;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    wr_full  = 1'b0;
    wr_done  = 1'b0;
    wr_clr   = 1'b0;
    err_next = 1'b0;
    wr_idx   = key_hit ? key_idx : free_idx;
    if (mgmt_valid) begin
      unique case (mgmt_op)
        OP_INSTALL, OP_OPEN: begin
          if (key_hit || free_any) wr_full = 1'b1;
          else                     err_next = 1'b1;
        end
        OP_COMPLETE: begin
          if (key_hit && ent_pend[key_idx]) wr_done = 1'b1;
          else                              err_next = 1'b1;
        end
        OP_REMOVE: begin
          if (key_hit) wr_clr = 1'b1;
          else         err_next = 1'b1;
        end
        default: err_next = 1'b1;
      endcase
    end
  end

  // Control flags carry reset; data fields do not.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      ent_pend  <= '0;
      mgmt_err  <= 1'b0;
    end else begin
      mgmt_err <= err_next;
      if (wr_full) begin
        ent_valid[wr_idx] <= 1'b1;
        ent_pend[wr_idx]  <= (mgmt_op == OP_OPEN);
      end else if (wr_done) begin
        ent_pend[wr_idx] <= 1'b0;
      end else if (wr_clr) begin
        ent_valid[wr_idx] <= 1'b0;
        ent_pend[wr_idx]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_full) begin
      ent_in_if[wr_idx]  <= mgmt_in_if;
      ent_in_vci[wr_idx] <= mgmt_in_vci;
      ent_out_if[wr_idx] <= mgmt_out_if;
    end
    if (wr_full || wr_done) begin
      ent_out_vci[wr_idx] <= mgmt_out_vci;
    end
  end
endmodule

// File: rtl/vcf_emit.sv
// Registered forwarding result and drop counter.
module vcf_emit #(
  parameter int IF_W  = 2,
  parameter int VCI_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_valid,
  input  logic             hit_active,
  input  logic [IF_W-1:0]  sel_if,
  input  logic [VCI_W-1:0] sel_vci,
  output logic             out_valid,
  output logic [IF_W-1:0]  out_if,
  output logic [VCI_W-1:0] out_vci,
  output logic             drop,
  output logic [CNT_W-1:0] miss_count
);
  logic fwd, miss;
  assign fwd  = pkt_valid && hit_active;
  assign miss = pkt_valid && !hit_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      drop       <= 1'b0;
      miss_count <= '0;
      out_if     <= '0;
      out_vci    <= '0;
    end else begin
      out_valid <= fwd;
      drop      <= miss;
      if (miss) miss_count <= miss_count + 1'b1;
      if (fwd) begin
        out_if  <= sel_if;
        out_vci <= sel_vci;
      end
    end
  end
endmodule

// File: rtl/vc_swap_fwd.sv
module vc_swap_fwd
  import vcf_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IF_W      = 2,
  parameter int VCI_W     = 8,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_valid_i,
  input  logic [IF_W-1:0]  pkt_if_i,
  input  logic [VCI_W-1:0] pkt_vci_i,
  output logic             out_valid_o,
  output logic [IF_W-1:0]  out_if_o,
  output logic [VCI_W-1:0] out_vci_o,
  output logic             drop_o,
  output logic [CNT_W-1:0] miss_count_o,
  input  logic             mgmt_valid_i,
  input  logic [1:0]       mgmt_op_i,
  input  logic [IF_W-1:0]  mgmt_in_if_i,
  input  logic [VCI_W-1:0] mgmt_in_vci_i,
  input  logic [IF_W-1:0]  mgmt_out_if_i,
  input  logic [VCI_W-1:0] mgmt_out_vci_i,
  output logic             mgmt_err_o
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [N_ENTRIES-1:0]            ent_valid, ent_pend, ent_active;
  logic [N_ENTRIES-1:0][IF_W-1:0]  ent_in_if, ent_out_if;
  logic [N_ENTRIES-1:0][VCI_W-1:0] ent_in_vci, ent_out_vci;
  logic [N_ENTRIES-1:0]            pkt_hit_vec, mg_hit_vec;
  logic                            pkt_hit, mg_hit;
  logic [IDX_W-1:0]                pkt_idx, mg_idx;

  assign ent_active = ent_valid & ~ent_pend;

  vcf_match #(.N(N_ENTRIES), .IF_W(IF_W), .VCI_W(VCI_W)) u_pkt_match (
    .ent_valid (ent_active),
    .ent_if    (ent_in_if),
    .ent_vci   (ent_in_vci),
    .key_if    (pkt_if_i),
    .key_vci   (pkt_vci_i),
    .hit_vec   (pkt_hit_vec),
    .hit       (pkt_hit),
    .hit_idx   (pkt_idx)
  );

  vcf_match #(.N(N_ENTRIES), .IF_W(IF_W), .VCI_W(VCI_W)) u_mgmt_match (
    .ent_valid (ent_valid),
    .ent_if    (ent_in_if),
    .ent_vci   (ent_in_vci),
    .key_if    (mgmt_in_if_i),
    .key_vci   (mgmt_in_vci_i),
    .hit_vec   (mg_hit_vec),
    .hit       (mg_hit),
    .hit_idx   (mg_idx)
  );

  vcf_table #(.N(N_ENTRIES), .IF_W(IF_W), .VCI_W(VCI_W)) u_table (
    .clk          (clk),
    .rst          (rst),
    .mgmt_valid   (mgmt_valid_i),
    .mgmt_op      (vcf_op_e'(mgmt_op_i)),
    .mgmt_in_if   (mgmt_in_if_i),
    .mgmt_in_vci  (mgmt_in_vci_i),
    .mgmt_out_if  (mgmt_out_if_i),
    .mgmt_out_vci (mgmt_out_vci_i),
    .key_hit      (mg_hit),
    .key_idx      (mg_idx),
    .ent_valid    (ent_valid),
    .ent_pend     (ent_pend),
    .ent_in_if    (ent_in_if),
    .ent_in_vci   (ent_in_vci),
    .ent_out_if   (ent_out_if),
    .ent_out_vci  (ent_out_vci),
    .mgmt_err     (mgmt_err_o)
  );

  vcf_emit #(.IF_W(IF_W), .VCI_W(VCI_W), .CNT_W(CNT_W)) u_emit (
    .clk        (clk),
    .rst        (rst),
    .pkt_valid  (pkt_valid_i),
    .hit_active (pkt_hit),
    .sel_if     (ent_out_if[pkt_idx]),
    .sel_vci    (ent_out_vci[pkt_idx]),
    .out_valid  (out_valid_o),
    .out_if     (out_if_o),
    .out_vci    (out_vci_o),
    .drop       (drop_o),
    .miss_count (miss_count_o)
  );
endmodule

// File: rtl/vcf_chk.sv
module vcf_chk #(
  parameter int IF_W  = 2,
  parameter int VCI_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pkt_valid_i,
  input logic             out_valid_o,
  input logic             drop_o,
  input logic [CNT_W-1:0] miss_count_o,
  input logic             mgmt_valid_i,
  input logic             mgmt_err_o
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    pkt_valid_i |=> (out_valid_o != drop_o)); // R5
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid_i |=> (!out_valid_o && !drop_o)); // R2
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> (miss_count_o == CNT_W'($past(miss_count_o) + 1'b1))); // R5
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !drop_o |-> $stable(miss_count_o)); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    mgmt_err_o |-> $past(mgmt_valid_i)); // R9
endmodule

bind vc_swap_fwd vcf_chk #(.IF_W(IF_W), .VCI_W(VCI_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pkt_valid_i  (pkt_valid_i),
  .out_valid_o  (out_valid_o),
  .drop_o       (drop_o),
  .miss_count_o (miss_count_o),
  .mgmt_valid_i (mgmt_valid_i),
  .mgmt_err_o   (mgmt_err_o)
);

// File: tb/tb_vc_swap_fwd.sv
module tb_vc_swap_fwd;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;

  logic       clk = 1'b0, rst = 1'b1;
  logic       pkt_valid_i = 1'b0;
  logic [1:0] pkt_if_i = '0;
  logic [7:0] pkt_vci_i = '0;
  logic       out_valid_o, drop_o, mgmt_err_o;
  logic [1:0] out_if_o;
  logic [7:0] out_vci_o;
  logic [15:0] miss_count_o;
  logic       mgmt_valid_i = 1'b0;
  logic [1:0] mgmt_op_i = '0, mgmt_in_if_i = '0, mgmt_out_if_i = '0;
  logic [7:0] mgmt_in_vci_i = '0, mgmt_out_vci_i = '0;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference model
  bit         m_pend [int];
  logic [1:0] m_oif  [int];
  logic [7:0] m_ovci [int];
  int         m_miss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_swap_fwd dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit pv, input logic [1:0] pif, input logic [7:0] pvci,
                      input bit mv, input logic [1:0] mop, input logic [1:0] mif,
                      input logic [7:0] mvci, input logic [1:0] moif,
                      input logic [7:0] movci, input string tag);
    int pk, mk;
    bit e_val, e_drop, e_err;
    int e_if, e_vci;
    @(negedge clk);
    pkt_valid_i = pv; pkt_if_i = pif; pkt_vci_i = pvci;
    mgmt_valid_i = mv; mgmt_op_i = mop; mgmt_in_if_i = mif; mgmt_in_vci_i = mvci;
    mgmt_out_if_i = moif; mgmt_out_vci_i = movci;
    pk = {pif, pvci};
    mk = {mif, mvci};
    e_val = pv && m_oif.exists(pk) && !m_pend[pk];
    e_drop = pv && !e_val;
    e_if = e_val ? int'(m_oif[pk]) : 0;
    e_vci = e_val ? int'(m_ovci[pk]) : 0;
    if (e_drop) m_miss++;
    e_err = 0;
    if (mv) begin
      case (mop)
        2'd0, 2'd1: begin
          if (m_oif.exists(mk) || m_oif.num() < NE) begin
            m_oif[mk] = moif; m_pend[mk] = (mop == 2'd1);
            if (mop == 2'd0) m_ovci[mk] = movci;
          end else e_err = 1;
        end
        2'd2: begin
          if (m_oif.exists(mk) && m_pend[mk]) begin
            m_ovci[mk] = movci; m_pend[mk] = 0;
          end else e_err = 1;
        end
        default: begin
          if (m_oif.exists(mk)) begin
            m_oif.delete(mk); m_pend.delete(mk); m_ovci.delete(mk);
          end else e_err = 1;
        end
      endcase
    end
    @(posedge clk); #1;
    chk(tag, "out_valid", int'(out_valid_o), int'(e_val));
    chk(tag, "drop", int'(drop_o), int'(e_drop));
    chk(tag, "miss_count", int'(miss_count_o), m_miss);
    chk(tag, "mgmt_err", int'(mgmt_err_o), int'(e_err));
    if (e_val) begin
      chk(tag, "out_if", int'(out_if_o), e_if);
      chk(tag, "out_vci", int'(out_vci_o), e_vci);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic look(input logic [1:0] pif, input logic [7:0] pvci, input string tag);
    step(1, pif, pvci, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic mg(input logic [1:0] mop, input logic [1:0] mif, input logic [7:0] mvci,
                    input logic [1:0] moif, input logic [7:0] movci, input string tag);
    step(0, 0, 0, 1, mop, mif, mvci, moif, movci, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "out_valid in reset", int'(out_valid_o), 0);
    chk("R10", "drop in reset", int'(drop_o), 0);
    chk("R10", "miss in reset", int'(miss_count_o), 0);
    chk("R10", "err in reset", int'(mgmt_err_o), 0);
    @(negedge clk); rst = 1'b0;
    idle("R10");
    look(2'd0, 8'd5, "R10");              // table empty after reset

    // R3 / R2: permanent install then forward with rewrite
    mg(2'd0, 2'd0, 8'd5, 2'd1, 8'd11, "R3");
    look(2'd0, 8'd5, "R2");
    look(2'd1, 8'd5, "R1");               // same id, other interface
    look(2'd0, 8'd6, "R5");
    mg(2'd0, 2'd2, 8'd5, 2'd3, 8'd40, "R1");
    look(2'd2, 8'd5, "R1");
    look(2'd0, 8'd5, "R1");

    // R4: pending entry, then completion
    mg(2'd1, 2'd3, 8'd11, 2'd2, 8'd0, "R4");
    look(2'd3, 8'd11, "R4");
    mg(2'd2, 2'd3, 8'd11, 2'd0, 8'd7, "R4");
    look(2'd3, 8'd11, "R4");

    // R9: refused operations
    mg(2'd2, 2'd3, 8'd11, 2'd0, 8'd9, "R9");   // not pending
    mg(2'd3, 2'd2, 8'd2, 2'd0, 8'd0, "R9");    // no entry
    mg(2'd2, 2'd1, 8'd77, 2'd0, 8'd9, "R9");   // no entry
    look(2'd3, 8'd11, "R9");

    // R8: lookup coincides with change of same entry
    step(1, 2'd0, 8'd5, 1, 2'd3, 2'd0, 8'd5, 2'd0, 8'd0, "R8");
    look(2'd0, 8'd5, "R6");
    step(1, 2'd3, 8'd11, 1, 2'd0, 2'd3, 8'd11, 2'd1, 8'd99, "R8");
    look(2'd3, 8'd11, "R7");
    step(1, 2'd2, 8'd5, 1, 2'd1, 2'd2, 8'd5, 2'd0, 8'd0, "R8");
    look(2'd2, 8'd5, "R4");

    // R7 / R6: fill table, reject, overwrite, free and reuse
    for (int i = 0; i < 14; i++) mg(2'd0, 2'd1, 8'(100 + i), 2'd2, 8'(i), "R7");
    mg(2'd0, 2'd2, 8'd200, 2'd1, 8'd33, "R7");
    look(2'd2, 8'd200, "R7");
    mg(2'd1, 2'd0, 8'd201, 2'd1, 8'd0, "R7");
    mg(2'd0, 2'd1, 8'd100, 2'd3, 8'd150, "R7");
    look(2'd1, 8'd100, "R7");
    mg(2'd3, 2'd1, 8'd101, 2'd0, 8'd0, "R6");
    look(2'd1, 8'd101, "R6");
    mg(2'd0, 2'd2, 8'd200, 2'd1, 8'd33, "R6");
    look(2'd2, 8'd200, "R6");
    for (int i = 2; i < 14; i++) look(2'd1, 8'(100 + i), "R2");
    idle("R2");
    idle("R5");
    finish_run();
  end
endmodule